// File: doc/BRIEF.md
# Trap-Level State Stack

This block holds the privileged trap context of one processor thread. It has one saved slot per trap level for five quantities: the trapped program counter, the trapped next program counter, the saved machine state, the trap type and the saved hypervisor state. Beside those slots it holds the current trap level, the trap vector base, the processor state word, the interrupt priority level, the hypervisor state word and the strand status word. All of these sit behind a single access port that is addressed by a register number. The five per-level quantities have no index of their own on the port. An access to one of them reaches the slot of level TL - 1, so the current trap level alone chooses the slot.

Each write is filtered by the register it targets. The vector base loses its low fifteen bits. The processor state keeps only its defined fields. The trap level saturates at the deepest level. The priority level keeps four bits. A trap-level write also re-evaluates a level-sensitive interrupt request. The request stands when the new level is zero, the hypervisor state has its "trap at level zero" bit set and the hypervisor privileged bit is clear.

A small access state machine is clocked on every cycle. In `ST_IDLE` no access was accepted in the last cycle. In `ST_RDATA` read data is being returned. In `ST_WACK` a write is being acknowledged. In `ST_FAULT` an access to an unknown register number is being flagged. The next state depends only on the access accepted in the current cycle, whatever the present state. The transitions are:
- `go_idle`: no valid access.
- `go_read`: a valid read of a known register.
- `go_write`: a valid write of a known register.
- `go_fault`: a valid access to an unknown number.

Top module: `trap_level_stack`

## Requirements
- R1: After reset, all per-level slots, TL, the vector base, the processor state and the priority level read as zero. The hypervisor state reads 0x800 (bit 11 set). The strand status reads 0x50000. rd_valid, wr_ack, acc_err and tlz_irq are all low.
- R2: The register numbers are 0 = saved PC, 1 = saved next PC, 2 = saved state, 3 = trap type and 4 = saved hypervisor state. While TL is between 1 and MAX_TL, each of these numbers reads and writes the slot of level TL - 1, and the levels are independent of each other.
- R3: While TL = 0, a read of numbers 0 to 4 returns zero and a write to them changes no slot.
- R4: Number 6 is the trap vector base. A write stores the data with bits 14:0 forced to zero.
- R5: Number 7 is the processor state. A write keeps only bits 1, 2, 3, 4, 6, 7, 8, 9 and 11 (mask 0xBDE), and every other bit reads as zero.
- R6: Number 5 is TL. A write to it sets tlz_irq if the hypervisor state has bit 0 set, the new TL is 0 and hypervisor bit 2 is clear. In every other case the write clears tlz_irq. Accesses to any other register leave tlz_irq unchanged.
- R7: A TL write larger than MAX_TL stores MAX_TL. Number 8 is the priority level, and a write to it keeps only bits 3:0.
- R8: A valid access is accepted on a rising edge, and a write takes effect on that edge. In the following cycle exactly one indication is high: rd_valid with the data on rd_data for a read, or wr_ack for a write. rd_data is zero in every cycle without rd_valid.
- R9: Register numbers 11 and above are unknown. An access to one raises acc_err for the following cycle only, returns zero on rd_data and changes no register.
- R10: Number 9, the hypervisor state, and number 10, the strand status, store and return the full data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_reg | input | 5 | Register number |
| acc_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data returned this cycle |
| rd_data | output | DATA_W | Read data, zero when rd_valid is low |
| wr_ack | output | 1 | Write acknowledged this cycle |
| acc_err | output | 1 | Previous access used an unknown number |
| tlz_irq | output | 1 | Trap-level-zero interrupt request |

## Verification
A trap-level write does two things on the same edge: it moves the slot index used by the following array access, and it re-evaluates tlz_irq against the hypervisor word written just before it. The bench issues these accesses back to back, with no idle cycle between them. It judges the slot read right after each level change against the pattern stored for that level. It judges tlz_irq against the value computed from the two written words. It then writes the hypervisor word alone and checks that the request holds its value, because only a trap-level write may change it.

// File: rtl/trapstk_pkg.sv
package trapstk_pkg;
    localparam int RNUM_W     = 5;
    localparam int ARR_KINDS  = 5;
    localparam int REG_COUNT  = 11;

    localparam logic [RNUM_W-1:0] RN_SAVED_PC   = 5'd0;
    localparam logic [RNUM_W-1:0] RN_SAVED_NPC  = 5'd1;
    localparam logic [RNUM_W-1:0] RN_SAVED_ST   = 5'd2;
    localparam logic [RNUM_W-1:0] RN_TRAP_TYPE  = 5'd3;
    localparam logic [RNUM_W-1:0] RN_SAVED_HST  = 5'd4;
    localparam logic [RNUM_W-1:0] RN_LEVEL      = 5'd5;
    localparam logic [RNUM_W-1:0] RN_VEC_BASE   = 5'd6;
    localparam logic [RNUM_W-1:0] RN_PROC_ST    = 5'd7;
    localparam logic [RNUM_W-1:0] RN_PRIO       = 5'd8;
    localparam logic [RNUM_W-1:0] RN_HYP_ST     = 5'd9;
    localparam logic [RNUM_W-1:0] RN_STRAND     = 5'd10;

    localparam logic [63:0] PROC_ST_KEEP  = 64'h0000_0000_0000_0BDE;
    localparam logic [63:0] VEC_BASE_KEEP = ~64'h0000_0000_0000_7FFF;
    localparam logic [63:0] HYP_ST_INIT   = 64'h0000_0000_0000_0800;
    localparam logic [63:0] STRAND_INIT   = 64'h0000_0000_0005_0000;
    localparam int          HYP_TLZ_BIT   = 0;
    localparam int          HYP_PRIV_BIT  = 2;
    localparam int          PRIO_W        = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RDATA = 2'd1,
        ST_WACK  = 2'd2,
        ST_FAULT = 2'd3
    } acc_state_e;
endpackage

// File: rtl/trapstk_level_bank.sv
module trapstk_level_bank #(
    parameter int DATA_W = 64,
    parameter int MAX_TL = 6,
    parameter int KINDS  = 5,
    localparam int LVL_W  = (MAX_TL > 1) ? $clog2(MAX_TL) : 1,
    localparam int KIND_W = (KINDS > 1) ? $clog2(KINDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LVL_W-1:0]  lvl,
    input  logic [KIND_W-1:0] kind,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CELLS = MAX_TL * KINDS;

    logic [DATA_W-1:0] cells [CELLS];

    for (genvar l = 0; l < MAX_TL; l++) begin : g_lvl
        for (genvar k = 0; k < KINDS; k++) begin : g_kind
            logic [DATA_W-1:0] cell_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cell_q <= '0;
                else if (wr_en && lvl == LVL_W'(l) && kind == KIND_W'(k))
                    cell_q <= wr_data;
            end
            assign cells[l*KINDS + k] = cell_q;
        end
    end

    always_comb begin
        int idx;
        idx = int'(lvl) * KINDS + int'(kind);
        rd_data = '0;
        if (idx < CELLS)
            rd_data = cells[idx];
    end
endmodule

// File: rtl/trapstk_ctl_regs.sv
module trapstk_ctl_regs
    import trapstk_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int MAX_TL = 6,
    localparam int TL_W  = $clog2(MAX_TL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RNUM_W-1:0] wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [TL_W-1:0]   tl_q,
    output logic [DATA_W-1:0] vbase_q,
    output logic [DATA_W-1:0] pstate_q,
    output logic [PRIO_W-1:0] prio_q,
    output logic [DATA_W-1:0] hstate_q,
    output logic [DATA_W-1:0] strand_q,
    output logic              tlz_irq
);
    localparam logic [DATA_W-1:0] PS_MASK = DATA_W'(PROC_ST_KEEP);
    localparam logic [DATA_W-1:0] VB_MASK = DATA_W'(VEC_BASE_KEEP);

    logic [TL_W-1:0] tl_new;
    logic            irq_new;

    always_comb begin
        if (wr_data > DATA_W'(MAX_TL))
            tl_new = TL_W'(MAX_TL);
        else
            tl_new = wr_data[TL_W-1:0];
        irq_new = hstate_q[HYP_TLZ_BIT] && (tl_new == '0) && !hstate_q[HYP_PRIV_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tl_q     <= '0;
            vbase_q  <= '0;
            pstate_q <= '0;
            prio_q   <= '0;
            hstate_q <= DATA_W'(HYP_ST_INIT);
            strand_q <= DATA_W'(STRAND_INIT);
            tlz_irq  <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_sel)
                RN_LEVEL: begin
                    tl_q    <= tl_new;
                    tlz_irq <= irq_new;
                end
                RN_VEC_BASE: vbase_q  <= wr_data & VB_MASK;
                RN_PROC_ST:  pstate_q <= wr_data & PS_MASK;
                RN_PRIO:     prio_q   <= wr_data[PRIO_W-1:0];
                RN_HYP_ST:   hstate_q <= wr_data;
                RN_STRAND:   strand_q <= wr_data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/trap_level_stack.sv
module trap_level_stack
    import trapstk_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int MAX_TL = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [4:0]        acc_reg,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_ack,
    output logic              acc_err,
    output logic              tlz_irq
);
    localparam int TL_W   = $clog2(MAX_TL + 1);
    localparam int LVL_W  = (MAX_TL > 1) ? $clog2(MAX_TL) : 1;
    localparam int KIND_W = $clog2(ARR_KINDS);

    acc_state_e state_q, state_d;

    logic              known, is_arr, lvl_ok;
    logic              bank_we, ctl_we;
    logic [LVL_W-1:0]  lvl_idx;
    logic [DATA_W-1:0] bank_rd, rd_mux, rdat_q;
    logic [TL_W-1:0]   tl_q;
    logic [DATA_W-1:0] vbase_q, pstate_q, hstate_q, strand_q;
    logic [PRIO_W-1:0] prio_q;

    always_comb begin
        known   = int'(acc_reg) < REG_COUNT;
        is_arr  = int'(acc_reg) < ARR_KINDS;
        lvl_ok  = tl_q != '0;
        lvl_idx = LVL_W'(tl_q - TL_W'(1));
        bank_we = acc_valid && acc_write && is_arr && lvl_ok;
        ctl_we  = acc_valid && acc_write && known && !is_arr;
    end

    trapstk_level_bank #(
        .DATA_W(DATA_W), .MAX_TL(MAX_TL), .KINDS(ARR_KINDS)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(bank_we), .lvl(lvl_idx),
        .kind(KIND_W'(acc_reg)), .wr_data(acc_wdata), .rd_data(bank_rd)
    );

    trapstk_ctl_regs #(
        .DATA_W(DATA_W), .MAX_TL(MAX_TL)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_we), .wr_sel(acc_reg),
        .wr_data(acc_wdata), .tl_q(tl_q), .vbase_q(vbase_q),
        .pstate_q(pstate_q), .prio_q(prio_q), .hstate_q(hstate_q),
        .strand_q(strand_q), .tlz_irq(tlz_irq)
    );

    always_comb begin
        rd_mux = '0;
        if (is_arr) begin
            if (lvl_ok)
                rd_mux = bank_rd;
        end else begin
            case (acc_reg)
                RN_LEVEL:    rd_mux = DATA_W'(tl_q);
                RN_VEC_BASE: rd_mux = vbase_q;
                RN_PROC_ST:  rd_mux = pstate_q;
                RN_PRIO:     rd_mux = DATA_W'(prio_q);
                RN_HYP_ST:   rd_mux = hstate_q;
                RN_STRAND:   rd_mux = strand_q;
                default:     rd_mux = '0;
            endcase
        end
    end

    // next state: go_idle / go_read / go_write / go_fault
    always_comb begin
        if (!acc_valid)
            state_d = ST_IDLE;
        else if (!known)
            state_d = ST_FAULT;
        else if (acc_write)
            state_d = ST_WACK;
        else
            state_d = ST_RDATA;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdat_q  <= '0;
        end else begin
            state_q <= state_d;
            rdat_q  <= (state_d == ST_RDATA) ? rd_mux : '0;
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        wr_ack   = 1'b0;
        acc_err  = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_RDATA: begin
                rd_valid = 1'b1;
                rd_data  = rdat_q;
            end
            ST_WACK:  wr_ack  = 1'b1;
            ST_FAULT: acc_err = 1'b1;
        endcase
    end
endmodule

// File: rtl/trapstk_chk.sv
module trapstk_chk #(
    parameter int DATA_W = 64,
    parameter int MAX_TL = 6,
    localparam int TL_W  = $clog2(MAX_TL + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [4:0]        acc_reg,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_ack,
    input logic              acc_err,
    input logic              tlz_irq,
    input logic [TL_W-1:0]   tl_q,
    input logic [DATA_W-1:0] pstate_q
);
    // R9
    bad_num_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_reg >= 5'd11) |=> (acc_err && rd_data == '0));
    // R9
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid) |=> !acc_err);
    // R8
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_reg < 5'd11) |=> rd_valid);
    // R8
    one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, wr_ack, acc_err}));
    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && acc_write && acc_reg == 5'd5) |=> $stable(tlz_irq));
    // R3
    lvl0_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_reg < 5'd5 && tl_q == '0) |=> rd_data == '0);
    // R7
    tl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tl_q) <= MAX_TL);
    // R5
    pstate_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate_q & ~DATA_W'(64'hBDE)) == '0);
endmodule

bind trap_level_stack trapstk_chk #(.DATA_W(DATA_W), .MAX_TL(MAX_TL)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_reg(acc_reg), .rd_valid(rd_valid), .rd_data(rd_data), .wr_ack(wr_ack),
    .acc_err(acc_err), .tlz_irq(tlz_irq), .tl_q(tl_q), .pstate_q(pstate_q)
);

// File: tb/tb_trap_level_stack.sv
module tb_trap_level_stack;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_TL     = 6;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [4:0]  acc_reg = '0;
    logic [63:0] acc_wdata = '0;
    logic        rd_valid, wr_ack, acc_err, tlz_irq;
    logic [63:0] rd_data;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_level_stack #(.DATA_W(64), .MAX_TL(MAX_TL)) dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_reg(acc_reg), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
        .rd_data(rd_data), .wr_ack(wr_ack), .acc_err(acc_err), .tlz_irq(tlz_irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    logic [63:0] q;
    logic        v, a, e;

    // called at a falling edge; returns at the next falling edge
    task automatic acc(input bit w, input logic [4:0] r, input logic [63:0] d);
        acc_valid = 1'b1; acc_write = w; acc_reg = r; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0;
        q = rd_data; v = rd_valid; a = wr_ack; e = acc_err;
    endtask

    function automatic logic [63:0] pat(input int l, input int k);
        return 64'h0123_4567_89AB_0000 ^ (64'(l) << 12) ^ (64'(k) << 4) ^ 64'h1;
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=done", WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 idle outputs
        chk(!rd_valid && !wr_ack && !acc_err && !tlz_irq, "R1 outputs", {rd_valid, wr_ack, acc_err, tlz_irq}, 0);
        @(negedge clk);
        for (int r = 0; r < 11; r++) begin
            logic [63:0] ex;
            ex = (r == 9) ? 64'h800 : (r == 10) ? 64'h50000 : 64'h0;
            acc(1'b0, 5'(r), '0);
            chk(v && q == ex, $sformatf("R1 reg%0d", r), q, ex);
        end
        // R2 fill every level, back to back TL writes then slot writes
        for (int l = 1; l <= MAX_TL; l++) begin
            acc(1'b1, 5'd5, 64'(l));
            chk(a, "R8 wr_ack", a, 1);
            for (int k = 0; k < 5; k++) acc(1'b1, 5'(k), pat(l, k));
        end
        for (int l = MAX_TL; l >= 1; l--) begin
            acc(1'b1, 5'd5, 64'(l));
            for (int k = 0; k < 5; k++) begin
                acc(1'b0, 5'(k), '0);
                chk(v && q == pat(l, k), $sformatf("R2 l%0d k%0d", l, k), q, pat(l, k));
            end
        end
        // R3 level zero
        acc(1'b1, 5'd5, 64'd0);
        for (int k = 0; k < 5; k++) begin
            acc(1'b0, 5'(k), '0);
            chk(v && q == 0, "R3 read at TL0", q, 0);
            acc(1'b1, 5'(k), 64'hFFFF_DEAD_BEEF_FFFF);
        end
        for (int l = 1; l <= MAX_TL; l++) begin
            acc(1'b1, 5'd5, 64'(l));
            for (int k = 0; k < 5; k++) begin
                acc(1'b0, 5'(k), '0);
                chk(q == pat(l, k), "R3 slot untouched", q, pat(l, k));
            end
        end
        // R4 / R5 / R10 / R7 pattern sweep
        for (int i = 0; i < 24; i++) begin
            logic [63:0] d;
            d = {32'(i) * 32'h9E37_79B9, 32'(i) * 32'h85EB_CA6B} ^ (64'h1 << i);
            acc(1'b1, 5'd6, d); acc(1'b0, 5'd6, '0);
            chk(q == (d & ~64'h7FFF), "R4 vector base", q, d & ~64'h7FFF);
            acc(1'b1, 5'd7, d); acc(1'b0, 5'd7, '0);
            chk(q == (d & 64'hBDE), "R5 proc state", q, d & 64'hBDE);
            acc(1'b1, 5'd10, d); acc(1'b0, 5'd10, '0);
            chk(q == d, "R10 strand", q, d);
            acc(1'b1, 5'd8, d); acc(1'b0, 5'd8, '0);
            chk(q == (d & 64'hF), "R7 priority", q, d & 64'hF);
        end
        for (int t = 0; t < 20; t++) begin
            logic [63:0] d, ex;
            d  = (t < 16) ? 64'(t) : (64'h1 << (40 + t));
            ex = (d > 64'(MAX_TL)) ? 64'(MAX_TL) : d;
            acc(1'b1, 5'd5, d); acc(1'b0, 5'd5, '0);
            chk(q == ex, "R7 TL clamp", q, ex);
        end
        // R6 interrupt sweep
        for (int tz = 0; tz < 2; tz++)
            for (int hp = 0; hp < 2; hp++)
                for (int nt = 0; nt < 3; nt++) begin
                    logic [63:0] hw;
                    logic        ex;
                    hw = 64'h800 | 64'(tz) | (64'(hp) << 2);
                    ex = (tz == 1) && (hp == 0) && (nt == 0);
                    acc(1'b1, 5'd9, hw);
                    acc(1'b1, 5'd5, 64'(nt * 3));
                    chk(tlz_irq == ex, $sformatf("R6 tz%0d hp%0d tl%0d", tz, hp, nt * 3), tlz_irq, ex);
                    acc(1'b1, 5'd9, hw ^ 64'h5);
                    chk(tlz_irq == ex, "R6 hold on hyp write", tlz_irq, ex);
                    acc(1'b0, 5'd9, '0);
                    chk(q == (hw ^ 64'h5), "R10 hyp state", q, hw ^ 64'h5);
                end
        // R9 unknown numbers
        acc(1'b1, 5'd6, 64'h0000_1234_5678_0000);
        for (int r = 11; r < 32; r++) begin
            acc(1'b0, 5'(r), '0);
            chk(e && !v && q == 0, $sformatf("R9 read %0d", r), {e, v, q[61:0]}, 64'h8000_0000_0000_0000);
            acc(1'b1, 5'(r), 64'hFFFF_FFFF_FFFF_FFFF);
            chk(e && !a, "R9 write err", {e, a}, 2);
            @(negedge clk);
            chk(!acc_err, "R9 err one cycle", acc_err, 0);
        end
        acc(1'b0, 5'd6, '0);
        chk(q == 64'h0000_1234_5678_0000, "R9 no state change", q, 64'h0000_1234_5678_0000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule